// File: doc/BRIEF.md
# Program and Data Stack Pointer Unit

This block owns the two 8-bit stack pointers of a small 8-bit CPU and turns each stack-related request into a sequence of single-cycle accesses to a 256-byte data RAM. The program stack holds return state. Interrupt entry and subroutine calls push a two-byte frame upward from the program pointer. Subroutine return and interrupt return pop that frame back. The data stack serves byte pushes and pops and grows downward from the data pointer. The block drives the RAM address, write data and write enable, and takes the RAM read data back combinationally in the same cycle.

The decoder issues one request per cycle with `op_valid_i` and `op_i`. It also supplies the program counter of the next instruction, the carry and zero flags, and the byte to push. For two-byte frames the block raises `busy_o` during the second access and ignores new requests in that cycle. Restored program counters and flags come back registered and are qualified by `done_o`. Popped data is qualified by `pop_valid_o`. The block also holds the global interrupt enable: interrupt entry clears it and interrupt return sets it. Software may load either pointer directly, but only in a cycle that carries no stack operation.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset both pointers read 0, the interrupt enable is 0, and `busy_o`, `done_o` and `pop_valid_o` are 0.
- R2: Interrupt entry (op 1) and call (op 2) write byte {carry, zero, pc[13:8]} at address P, where P is the program pointer when the request is accepted. They then write pc[7:0] at P+1 in the next cycle. The program pointer ends at P+2, having risen by one after each write.
- R3: Interrupt entry clears the interrupt enable one cycle after acceptance. A call leaves the enable unchanged.
- R4: Interrupt return (op 4) reads P-1 in the accept cycle and P-2 in the next cycle. The program pointer ends at P-2. In the cycle after the second read, `done_o` is 1 and `pc_o` holds {byte(P-2)[5:0], byte(P-1)}. In that same cycle `carry_o` = byte(P-2)[7], `zero_o` = byte(P-2)[6], and the interrupt enable is 1.
- R5: Subroutine return (op 3) follows the same access order and pointer change as R4, and restores `pc_o` the same way. It leaves `carry_o`, `zero_o` and the interrupt enable unchanged.
- R6: A data push (op 5) writes `push_data_i` at D-1, where D is the data pointer, and the data pointer becomes D-1. With D = 0 the byte goes to address 0xFF and the pointer becomes 0xFF.
- R7: A data pop (op 6) reads address D. In the next cycle `pop_valid_o` is 1 and `pop_data_o` holds that byte, and the data pointer is D+1, wrapping from 0xFF to 0.
- R8: `busy_o` is 1 for exactly the second cycle of a two-byte frame. Any request presented in that cycle, and any direct pointer write, is ignored.
- R9: A direct write (`psp_wr_i` or `dsp_wr_i` with `ptr_wdata_i`) loads the pointer by the next cycle when no operation is accepted. It is rejected when an operation is accepted in the same cycle. Without an operation or a write, a pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation request strobe |
| op_i | input | 3 | Operation code: 1 int entry, 2 call, 3 ret, 4 reti, 5 push, 6 pop, 0/7 none |
| pc_i | input | 14 | Program counter of the next instruction |
| carry_i | input | 1 | Carry flag to save |
| zero_i | input | 1 | Zero flag to save |
| push_data_i | input | 8 | Byte for a data push |
| psp_wr_i | input | 1 | Direct load of the program pointer |
| dsp_wr_i | input | 1 | Direct load of the data pointer |
| ptr_wdata_i | input | 8 | Value for a direct pointer load |
| ram_rdata_i | input | 8 | RAM read data for `ram_addr_o`, same cycle |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| busy_o | output | 1 | Second access of a two-byte frame in progress |
| done_o | output | 1 | Restored program counter valid |
| pc_o | output | 14 | Restored program counter |
| carry_o | output | 1 | Restored carry flag |
| zero_o | output | 1 | Restored zero flag |
| pop_data_o | output | 8 | Popped byte |
| pop_valid_o | output | 1 | Popped byte valid |
| int_en_o | output | 1 | Global interrupt enable |
| psp_o | output | 8 | Program stack pointer |
| dsp_o | output | 8 | Data stack pointer |

## Verification
The unit is driven with long random mixes of the six operations and with direct pointer loads. These mixes show that frames saved by entry or call come back intact through either return type. They also show that the two pointers never disturb each other. Directed patterns cover the cases that random traffic rarely reaches. A push from pointer 0 separates correct wrap-around to 0xFF from an underflow bug. A return after an interrupt return separates flag restore from flag preservation. A request or pointer load during the busy cycle, and a pointer load that collides with an accepted operation, each check that the operation has precedence over the load.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int PC_W    = 14;
  localparam int PC_HI_W = PC_W - DATA_W;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_INT  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_PUSH = 3'd5,
    OP_POP  = 3'd6,
    OP_RSVD = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE2 = 2'd1,
    ST_RSTR2 = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] ptr_m1_o
);
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (inc_i) ptr_q <= ptr_q + W'(1);
    else if (dec_i) ptr_q <= ptr_q - W'(1);
    else if (ld_i)  ptr_q <= ld_val_i;
  end

  assign ptr_o    = ptr_q;
  assign ptr_m1_o = ptr_q - W'(1);

  AST_PTR_CTRL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inc_i, dec_i, ld_i})); // R9
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [2:0]         op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               carry_i,
  input  logic               zero_i,
  input  logic [DATA_W-1:0]  push_data_i,
  input  logic               psp_wr_i,
  input  logic               dsp_wr_i,
  input  logic [ADDR_W-1:0]  psp_i,
  input  logic [ADDR_W-1:0]  psp_m1_i,
  input  logic [ADDR_W-1:0]  dsp_i,
  input  logic [ADDR_W-1:0]  dsp_m1_i,
  input  logic [DATA_W-1:0]  ram_rdata_i,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic [DATA_W-1:0]  ram_wdata_o,
  output logic               ram_we_o,
  output logic               psp_inc_o,
  output logic               psp_dec_o,
  output logic               psp_ld_o,
  output logic               dsp_inc_o,
  output logic               dsp_dec_o,
  output logic               dsp_ld_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               carry_o,
  output logic               zero_o,
  output logic [DATA_W-1:0]  pop_data_o,
  output logic               pop_valid_o,
  output logic               int_en_o
);
  stk_state_e          state_q;
  stk_op_e             op;
  logic                accept;
  logic [DATA_W-1:0]   lo_q;
  logic                reti_q;
  logic                done_q, popv_q, ie_q, carry_q, zero_q;
  logic [PC_W-1:0]     pc_q;
  logic [DATA_W-1:0]   pop_q;

  assign op     = stk_op_e'(op_i);
  assign accept = op_valid_i && (state_q == ST_IDLE) &&
                  (op != OP_NONE) && (op != OP_RSVD);

  always_comb begin
    ram_addr_o  = psp_i;
    ram_wdata_o = '0;
    ram_we_o    = 1'b0;
    psp_inc_o   = 1'b0;
    psp_dec_o   = 1'b0;
    dsp_inc_o   = 1'b0;
    dsp_dec_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_INT, OP_CALL: begin
              ram_addr_o  = psp_i;
              ram_wdata_o = {carry_i, zero_i, pc_i[PC_W-1:DATA_W]};
              ram_we_o    = 1'b1;
              psp_inc_o   = 1'b1;
            end
            OP_RET, OP_RETI: begin
              ram_addr_o = psp_m1_i;
              psp_dec_o  = 1'b1;
            end
            OP_PUSH: begin
              ram_addr_o  = dsp_m1_i;
              ram_wdata_o = push_data_i;
              ram_we_o    = 1'b1;
              dsp_dec_o   = 1'b1;
            end
            OP_POP: begin
              ram_addr_o = dsp_i;
              dsp_inc_o  = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_SAVE2: begin
        ram_addr_o  = psp_i;
        ram_wdata_o = lo_q;
        ram_we_o    = 1'b1;
        psp_inc_o   = 1'b1;
      end
      ST_RSTR2: begin
        ram_addr_o = psp_m1_i;
        psp_dec_o  = 1'b1;
      end
      default: ;
    endcase
  end

  // direct loads lose to any accepted or running operation
  assign psp_ld_o = psp_wr_i && (state_q == ST_IDLE) && !accept;
  assign dsp_ld_o = dsp_wr_i && (state_q == ST_IDLE) && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      reti_q  <= 1'b0;
      done_q  <= 1'b0;
      popv_q  <= 1'b0;
      ie_q    <= 1'b0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      pc_q    <= '0;
      pop_q   <= '0;
    end else begin
      done_q <= (state_q == ST_RSTR2);
      popv_q <= accept && (op == OP_POP);
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            unique case (op)
              OP_INT, OP_CALL: begin
                state_q <= ST_SAVE2;
                lo_q    <= pc_i[DATA_W-1:0];
                if (op == OP_INT) ie_q <= 1'b0;
              end
              OP_RET, OP_RETI: begin
                state_q <= ST_RSTR2;
                lo_q    <= ram_rdata_i;
                reti_q  <= (op == OP_RETI);
              end
              OP_POP:  pop_q <= ram_rdata_i;
              default: ;
            endcase
          end
        end
        ST_SAVE2: state_q <= ST_IDLE;
        ST_RSTR2: begin
          state_q <= ST_IDLE;
          pc_q    <= {ram_rdata_i[PC_HI_W-1:0], lo_q};
          if (reti_q) begin
            carry_q <= ram_rdata_i[DATA_W-1];
            zero_q  <= ram_rdata_i[DATA_W-2];
            ie_q    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign pc_o        = pc_q;
  assign carry_o     = carry_q;
  assign zero_o      = zero_q;
  assign pop_data_o  = pop_q;
  assign pop_valid_o = popv_q;
  assign int_en_o    = ie_q;

  AST_BUSY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !pop_valid_o); // R4
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [2:0]         op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               carry_i,
  input  logic               zero_i,
  input  logic [DATA_W-1:0]  push_data_i,
  input  logic               psp_wr_i,
  input  logic               dsp_wr_i,
  input  logic [ADDR_W-1:0]  ptr_wdata_i,
  input  logic [DATA_W-1:0]  ram_rdata_i,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic [DATA_W-1:0]  ram_wdata_o,
  output logic               ram_we_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               carry_o,
  output logic               zero_o,
  output logic [DATA_W-1:0]  pop_data_o,
  output logic               pop_valid_o,
  output logic               int_en_o,
  output logic [ADDR_W-1:0]  psp_o,
  output logic [ADDR_W-1:0]  dsp_o
);
  logic [ADDR_W-1:0] psp, psp_m1, dsp, dsp_m1;
  logic psp_inc, psp_dec, psp_ld, dsp_inc, dsp_dec, dsp_ld;

  stk_ptr_reg #(.W(ADDR_W)) u_psp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (psp_inc),
    .dec_i    (psp_dec),
    .ld_i     (psp_ld),
    .ld_val_i (ptr_wdata_i),
    .ptr_o    (psp),
    .ptr_m1_o (psp_m1)
  );

  stk_ptr_reg #(.W(ADDR_W)) u_dsp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (dsp_inc),
    .dec_i    (dsp_dec),
    .ld_i     (dsp_ld),
    .ld_val_i (ptr_wdata_i),
    .ptr_o    (dsp),
    .ptr_m1_o (dsp_m1)
  );

  stk_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .op_i        (op_i),
    .pc_i        (pc_i),
    .carry_i     (carry_i),
    .zero_i      (zero_i),
    .push_data_i (push_data_i),
    .psp_wr_i    (psp_wr_i),
    .dsp_wr_i    (dsp_wr_i),
    .psp_i       (psp),
    .psp_m1_i    (psp_m1),
    .dsp_i       (dsp),
    .dsp_m1_i    (dsp_m1),
    .ram_rdata_i (ram_rdata_i),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_we_o    (ram_we_o),
    .psp_inc_o   (psp_inc),
    .psp_dec_o   (psp_dec),
    .psp_ld_o    (psp_ld),
    .dsp_inc_o   (dsp_inc),
    .dsp_dec_o   (dsp_dec),
    .dsp_ld_o    (dsp_ld),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pc_o        (pc_o),
    .carry_o     (carry_o),
    .zero_o      (zero_o),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .int_en_o    (int_en_o)
  );

  assign psp_o = psp;
  assign dsp_o = dsp;

  AST_SAVE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && (op_i == 3'd1 || op_i == 3'd2))
      |=> busy_o && psp_o == $past(psp_o) + ADDR_W'(1)); // R2
  AST_SAVE_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ram_we_o) |=> psp_o == $past(psp_o) + ADDR_W'(1)); // R2
  AST_INT_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_i == 3'd1) |=> !int_en_o); // R3
  AST_RSTR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ram_we_o) |=> done_o && !busy_o); // R4
  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_i == 3'd5)
      |=> dsp_o == $past(dsp_o) - ADDR_W'(1)); // R6
  AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_i == 3'd6)
      |=> pop_valid_o && dsp_o == $past(dsp_o) + ADDR_W'(1)); // R7
  AST_PSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !psp_wr_i && !(op_valid_i && op_i inside {3'd1, 3'd2, 3'd3, 3'd4}))
      |=> $stable(psp_o)); // R9
endmodule

// File: tb/stk_ptr_unit_tb_top.sv
module stk_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [13:0] pc = '0;
  logic        carry = 1'b0, zero = 1'b0;
  logic [7:0]  push_data = '0;
  logic        psp_wr = 1'b0, dsp_wr = 1'b0;
  logic [7:0]  ptr_wdata = '0;
  logic [7:0]  ram_rdata, ram_addr, ram_wdata;
  logic        ram_we, busy, done, carry_o, zero_o, pop_valid, int_en;
  logic [13:0] pc_o;
  logic [7:0]  pop_data, psp, dsp;
  logic [7:0]  mem [256];

  int errs = 0, checks = 0;
  logic [7:0] exp_psp = '0, exp_dsp = '0;
  logic       exp_ie = 1'b0, exp_c = 1'b0, exp_z = 1'b0;

  always #5 clk = ~clk;

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  stk_ptr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .pc_i(pc),
    .carry_i(carry), .zero_i(zero), .push_data_i(push_data), .psp_wr_i(psp_wr),
    .dsp_wr_i(dsp_wr), .ptr_wdata_i(ptr_wdata), .ram_rdata_i(ram_rdata),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_we_o(ram_we),
    .busy_o(busy), .done_o(done), .pc_o(pc_o), .carry_o(carry_o), .zero_o(zero_o),
    .pop_data_o(pop_data), .pop_valid_o(pop_valid), .int_en_o(int_en),
    .psp_o(psp), .dsp_o(dsp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_hi(input logic [13:0] p, input logic c, input logic z);
    return {c, z, p[13:8]};
  endfunction

  task automatic chk_ptrs(input string req);
    chk(psp == exp_psp, {req, " psp"}, psp, exp_psp);
    chk(dsp == exp_dsp, {req, " dsp"}, dsp, exp_dsp);
    chk(int_en == exp_ie, {req, " int_en"}, int_en, exp_ie);
  endtask

  task automatic do_op(input logic [2:0] o, input logic [13:0] p, input logic c,
                       input logic z, input logic [7:0] pd);
    logic [7:0] a0, a1, lo, hi, pv;
    a0 = exp_psp; a1 = exp_psp + 8'd1;
    lo = mem[8'(exp_psp - 8'd1)];
    hi = mem[8'(exp_psp - 8'd2)];
    pv = mem[exp_dsp];
    @(negedge clk);
    op_valid = 1'b1; op = o; pc = p; carry = c; zero = z; push_data = pd;
    @(negedge clk);
    op_valid = 1'b0;
    case (o)
      3'd1, 3'd2: begin
        chk(busy == 1'b1, "R8 busy save", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy end", busy, 0);
        chk(mem[a0] == frame_hi(p, c, z), "R2 byte hi", mem[a0], frame_hi(p, c, z));
        chk(mem[a1] == p[7:0], "R2 byte lo", mem[a1], p[7:0]);
        exp_psp = exp_psp + 8'd2;
        if (o == 3'd1) exp_ie = 1'b0;
        chk_ptrs("R2 R3");
      end
      3'd3, 3'd4: begin
        chk(busy == 1'b1, "R8 busy restore", busy, 1);
        @(negedge clk);
        chk(done == 1'b1, "R4 done", done, 1);
        chk(pc_o == {hi[5:0], lo}, "R4 R5 pc", pc_o, {hi[5:0], lo});
        if (o == 3'd4) begin
          exp_c = hi[7]; exp_z = hi[6]; exp_ie = 1'b1;
        end
        chk(carry_o == exp_c, "R4 R5 carry", carry_o, exp_c);
        chk(zero_o == exp_z, "R4 R5 zero", zero_o, exp_z);
        exp_psp = exp_psp - 8'd2;
        chk_ptrs("R4 R5");
      end
      3'd5: begin
        chk(busy == 1'b0, "R8 push single", busy, 0);
        exp_dsp = exp_dsp - 8'd1;
        chk(mem[exp_dsp] == pd, "R6 push data", mem[exp_dsp], pd);
        chk_ptrs("R6");
      end
      3'd6: begin
        chk(pop_valid == 1'b1, "R7 pop valid", pop_valid, 1);
        chk(pop_data == pv, "R7 pop data", pop_data, pv);
        exp_dsp = exp_dsp + 8'd1;
        chk_ptrs("R7");
      end
      default: ;
    endcase
  endtask

  task automatic set_ptr(input bit which, input logic [7:0] v);
    @(negedge clk);
    psp_wr = !which; dsp_wr = which; ptr_wdata = v;
    @(negedge clk);
    psp_wr = 1'b0; dsp_wr = 1'b0;
    if (which) exp_dsp = v; else exp_psp = v;
    chk_ptrs("R9 load");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    logic [7:0] d0, p0, m0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(psp == 8'd0 && dsp == 8'd0, "R1 pointers", {psp, dsp}, 0);
    chk(int_en == 1'b0 && busy == 1'b0, "R1 enable busy", {int_en, busy}, 0);
    chk(done == 1'b0 && pop_valid == 1'b0, "R1 strobes", {done, pop_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 push from zero wraps to 0xFF, R7 pop wraps back to zero
    do_op(3'd5, '0, 1'b0, 1'b0, 8'hA5);
    chk(dsp == 8'hFF, "R6 wrap", dsp, 8'hFF);
    do_op(3'd6, '0, 1'b0, 1'b0, 8'h00);
    chk(pop_data == 8'hA5 && dsp == 8'h00, "R7 wrap", {pop_data, dsp}, 16'hA500);

    // R3 entry then R4 return restores flags and enable; R5 keeps them
    do_op(3'd1, 14'h2ABC, 1'b1, 1'b0, 8'h0);
    do_op(3'd4, '0, 1'b0, 1'b0, 8'h0);
    chk(pc_o == 14'h2ABC && carry_o && !zero_o && int_en, "R4 frame", pc_o, 14'h2ABC);
    do_op(3'd2, 14'h1234, 1'b0, 1'b1, 8'h0);
    chk(int_en == 1'b1, "R3 call keeps enable", int_en, 1);
    do_op(3'd3, '0, 1'b0, 1'b0, 8'h0);
    chk(pc_o == 14'h1234 && carry_o && !zero_o, "R5 flags kept", {carry_o, zero_o}, 2'b10);

    // R9 load collides with accepted call: call wins
    p0 = psp;
    @(negedge clk);
    op_valid = 1'b1; op = 3'd2; pc = 14'h0777; psp_wr = 1'b1; ptr_wdata = 8'h55;
    @(negedge clk);
    op_valid = 1'b0; psp_wr = 1'b0;
    // R8 request and load during busy are ignored
    d0 = dsp; m0 = mem[8'(dsp - 8'd1)];
    op_valid = 1'b1; op = 3'd5; push_data = 8'h3C; dsp_wr = 1'b1; ptr_wdata = 8'h99;
    @(negedge clk);
    op_valid = 1'b0; dsp_wr = 1'b0;
    exp_psp = p0 + 8'd2;
    chk(psp == exp_psp, "R9 collision psp", psp, exp_psp);
    chk(dsp == d0, "R8 busy ignores", dsp, d0);
    chk(mem[8'(d0 - 8'd1)] == m0, "R8 no push write", mem[8'(d0 - 8'd1)], m0);
    chk(mem[8'(p0 + 8'd1)] == 8'h77, "R2 collision frame", mem[8'(p0 + 8'd1)], 8'h77);

    set_ptr(1'b0, 8'h40);
    set_ptr(1'b1, 8'hC0);
    // R9 idle hold
    repeat (3) @(negedge clk);
    chk_ptrs("R9 hold");

    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 7) set_ptr(1'($urandom), 8'($urandom));
      else if (r == 0) begin
        @(negedge clk);
        chk_ptrs("R9 idle");
      end else
        do_op(3'(r), 14'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
    end
    summary();
  end
endmodule